// File: doc/BRIEF.md
# Indexed Vector Atomic Memory Sequencer

This block carries out one indexed vector atomic memory instruction, element by element. It receives a scalar base address, a vector of index offsets, a vector of source data, a mask, the vector length and the element/memory width settings. For every active element it adds the index to the base and performs a read-modify-write at that address through a single-port memory interface. On request, it returns the value read from memory into the vector that is handed back.

Every active address is first checked on a permission port for both load and store rights. No memory is touched until all of them pass. A failed check ends the instruction with memory unchanged. A legality check runs at start. An illegal setting finishes the instruction at once, with no access and no result. Elements past the vector length are zeroed in the returned vector. A length of zero completes without any effect.

Vectors are flat buses of `VLMAX` slots, each 64 bits wide. Slot k occupies bits [64k+63:64k].

Top module: `vamo_seq`

## Requirements
- R1: The 5-bit op code selects the operation: 00001 swap, 00000 add, 00100 xor, 01100 and, 01000 or, 10000 signed min, 10100 signed max, 11000 unsigned min, 11100 unsigned max. The value written to memory is op(memory value, element value).
- R2: The instruction is illegal if any of these holds: the op code is not in the R1 set; the width code is neither 110 (32-bit memory) nor 111 (64-bit memory); the SEW code (0=8, 1=16, 2=32, 3=64 bits) is below 2; SEW exceeds XLEN; width 111 is used with SEW 32; or vl exceeds VLMAX. An illegal instruction pulses `done` with `illegal`=1, `dst_valid`=0, and makes no memory request.
- R3: The element address is base + index. With SEW 64 the index is the whole 64-bit slot. With SEW 32 it is the low 32 bits of the slot, zero-extended.
- R4: When `vm`=0, an element whose mask bit is 0 makes no memory request and keeps its slot. A successful run makes exactly two memory requests (one read, one write) per active element.
- R5: Before any memory request, every active element 0..vl-1 is checked on the permission port. If either the load or the store right is refused, the instruction ends with `fault`=1, `dst_valid`=0 and no memory request at all.
- R6: Active elements are processed in ascending order. Each issues a read, then, two cycles later, a write to the same address. A repeated address therefore sees the result of the earlier element.
- R7: With `wd`=1, each active slot receives the value read from memory. With `wd`=0, body slots are returned unchanged.
- R8: With vl=0 and a legal setting, `done` rises in the cycle after `start` is accepted. There is no memory request, and `dst_valid`, `illegal` and `fault` are all 0.
- R9: On success, slots vl..VLMAX-1 of `dst_vec` are zero.
- R10: Min and max keep the memory value when the operands are equal. The signed variants compare as two's complement at the memory width. The unsigned variants compare as unsigned at the memory width.
- R11: With 32-bit memory, only the low 32 bits are stored, and `mem_wdata[63:32]` is 0. With SEW 64, the loaded 32-bit value is sign-extended before writeback. With SEW 32, a written slot holds the loaded value in bits [31:0] and zero above.
- R12: Add wraps modulo the memory width. Swap stores the element value unchanged.
- R13: After reset the block is idle with no requests. An accepted `start` makes `busy` high in the next cycle. `done` is a one-cycle pulse. `start` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an instruction (taken only while idle) |
| funct5 | input | 5 | Operation code (R1) |
| width | input | 3 | Memory width code, 110 or 111 |
| sew | input | 2 | Element width code |
| vm | input | 1 | 1 = all elements active, 0 = use mask |
| wd | input | 1 | Write the old memory value back to the element |
| vl | input | CNT_W | Vector length |
| base | input | XLEN | Scalar base address |
| index_vec | input | VLMAX*64 | Index offsets, one per slot |
| data_vec | input | VLMAX*64 | Source element values |
| mask | input | VLMAX | Per-element mask bits |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Completion status: illegal setting |
| fault | output | 1 | Completion status: permission refused |
| dst_valid | output | 1 | With done: dst_vec is to be written back |
| dst_vec | output | VLMAX*64 | Resulting vector |
| chk_req | output | 1 | Permission query valid |
| chk_addr | output | XLEN | Address being queried |
| chk_ld_ok | input | 1 | Load right granted (same cycle) |
| chk_st_ok | input | 1 | Store right granted (same cycle) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_size64 | output | 1 | 1 = 64-bit access, 0 = 32-bit access |
| mem_addr | output | XLEN | Access address |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, valid the cycle after a read request |

## Verification
The assertions assume that the memory returns read data in the cycle after a read request. They also assume that the permission port answers combinationally in the cycle of the query. The bench memory model and permission model are built to respect both. The stimulus keeps every generated address inside the bench memory window: bases and indices are multiples of 8 and small, and with SEW 32 only the high index bits carry random junk, which the zero-extension rule discards. Random runs draw repeated indices on purpose, so that ordering between elements that share an address is exercised.

// File: rtl/vamo_pkg.sv
// Shared types and codes of the indexed vector atomic sequencer.
// Assumes a 64-bit maximum element width.
package vamo_pkg;
    localparam int ELEN = 64;

    typedef enum logic [3:0] {
        OP_SWAP, OP_ADD, OP_XOR, OP_AND, OP_OR,
        OP_MIN, OP_MAX, OP_MINU, OP_MAXU
    } amo_op_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_CHK, ST_RD, ST_LD, ST_WR, ST_FIN
    } seq_state_e;

    localparam logic [4:0] F5_SWAP = 5'b00001;
    localparam logic [4:0] F5_ADD  = 5'b00000;
    localparam logic [4:0] F5_XOR  = 5'b00100;
    localparam logic [4:0] F5_AND  = 5'b01100;
    localparam logic [4:0] F5_OR   = 5'b01000;
    localparam logic [4:0] F5_MIN  = 5'b10000;
    localparam logic [4:0] F5_MAX  = 5'b10100;
    localparam logic [4:0] F5_MINU = 5'b11000;
    localparam logic [4:0] F5_MAXU = 5'b11100;

    localparam logic [2:0] WID_M32 = 3'b110;
    localparam logic [2:0] WID_M64 = 3'b111;
    localparam logic [1:0] SEW_E32 = 2'd2;
    localparam logic [1:0] SEW_E64 = 2'd3;
endpackage

// File: rtl/vamo_decode.sv
// Decodes the op code and width settings and decides legality.
// Assumes the inputs are stable in the cycle start is accepted.
module vamo_decode
    import vamo_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int VLMAX = 8,
    localparam int CNT_W = $clog2(VLMAX + 1)
) (
    input  logic [4:0]       funct5,
    input  logic [2:0]       width,
    input  logic [1:0]       sew,
    input  logic [CNT_W-1:0] vl,
    output logic             legal,
    output amo_op_e          op,
    output logic             mem64,
    output logic             elem64
);
    logic op_known;
    logic sew_ok;
    logic wid_ok;
    logic vl_ok;

    // Map the op code onto the internal operation.
    always_comb begin
        op_known = 1'b1;
        op       = OP_SWAP;
        unique case (funct5)
            F5_SWAP: op = OP_SWAP;
            F5_ADD:  op = OP_ADD;
            F5_XOR:  op = OP_XOR;
            F5_AND:  op = OP_AND;
            F5_OR:   op = OP_OR;
            F5_MIN:  op = OP_MIN;
            F5_MAX:  op = OP_MAX;
            F5_MINU: op = OP_MINU;
            F5_MAXU: op = OP_MAXU;
            default: op_known = 1'b0;
        endcase
    end

    // Width rules: SEW at least 32, at most XLEN, never narrower than memory.
    always_comb begin
        elem64 = (sew == SEW_E64);
        mem64  = (width == WID_M64);
        sew_ok = (sew == SEW_E32) || (elem64 && (XLEN >= 64));
        wid_ok = (width == WID_M32) || (mem64 && elem64);
        vl_ok  = (vl <= CNT_W'(VLMAX));
        legal  = op_known && sew_ok && wid_ok && vl_ok;
    end
endmodule

// File: rtl/vamo_addr_gen.sv
// Forms base + index for every element slot in parallel.
// Assumes 64-bit index slots; with 32-bit elements only the low half counts.
module vamo_addr_gen
    import vamo_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int VLMAX = 8
) (
    input  logic [XLEN-1:0]             base,
    input  logic [VLMAX*ELEN-1:0]       index_vec,
    input  logic                        elem64,
    output logic [VLMAX-1:0][XLEN-1:0]  elem_addr
);
    for (genvar g = 0; g < VLMAX; g++) begin : g_slot
        logic [ELEN-1:0] raw;
        logic [ELEN-1:0] ofs;
        // Select the index width and add it to the base for slot g.
        always_comb begin
            raw          = index_vec[g*ELEN +: ELEN];
            ofs          = elem64 ? raw : {32'b0, raw[31:0]};
            elem_addr[g] = base + ofs[XLEN-1:0];
        end
    end
endmodule

// File: rtl/vamo_alu.sv
// Combines the memory value with the element value at the memory width.
// Assumes 32-bit operands sit in the low half of the 64-bit inputs.
module vamo_alu
    import vamo_pkg::*;
(
    input  amo_op_e          op,
    input  logic             mem64,
    input  logic [ELEN-1:0]  mem_val,
    input  logic [ELEN-1:0]  vec_val,
    output logic [ELEN-1:0]  store_val
);
    logic            sgn;
    logic [ELEN-1:0] a;
    logic [ELEN-1:0] b;
    logic            a_ge_b;
    logic [ELEN-1:0] res;

    // Widen both operands so one 64-bit compare serves both widths.
    always_comb begin
        sgn    = (op == OP_MIN) || (op == OP_MAX);
        a      = mem64 ? mem_val : {{32{sgn & mem_val[31]}}, mem_val[31:0]};
        b      = mem64 ? vec_val : {{32{sgn & vec_val[31]}}, vec_val[31:0]};
        a_ge_b = sgn ? ($signed(a) >= $signed(b)) : (a >= b);
    end

    // Apply the operation; ties in min/max keep the memory value.
    always_comb begin
        unique case (op)
            OP_SWAP: res = b;
            OP_ADD:  res = a + b;
            OP_XOR:  res = a ^ b;
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_MIN,
            OP_MINU: res = a_ge_b ? b : a;
            OP_MAX,
            OP_MAXU: res = a_ge_b ? a : b;
            default: res = b;
        endcase
        store_val = mem64 ? res : {32'b0, res[31:0]};
    end
endmodule

// File: rtl/vamo_seq.sv
// Sequencer for one indexed vector atomic instruction. It runs a permission
// pass over all active elements, then one read-modify-write per active
// element in ascending order, then zeroes the tail slots.
// Assumes memory read data arrives the cycle after a read request and the
// permission port answers in the same cycle as the query.
module vamo_seq
    import vamo_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int VLMAX = 8,
    localparam int CNT_W = $clog2(VLMAX + 1),
    localparam int VW    = VLMAX * ELEN
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [4:0]       funct5,
    input  logic [2:0]       width,
    input  logic [1:0]       sew,
    input  logic             vm,
    input  logic             wd,
    input  logic [CNT_W-1:0] vl,
    input  logic [XLEN-1:0]  base,
    input  logic [VW-1:0]    index_vec,
    input  logic [VW-1:0]    data_vec,
    input  logic [VLMAX-1:0] mask,
    output logic             busy,
    output logic             done,
    output logic             illegal,
    output logic             fault,
    output logic             dst_valid,
    output logic [VW-1:0]    dst_vec,
    output logic             chk_req,
    output logic [XLEN-1:0]  chk_addr,
    input  logic             chk_ld_ok,
    input  logic             chk_st_ok,
    output logic             mem_req,
    output logic             mem_we,
    output logic             mem_size64,
    output logic [XLEN-1:0]  mem_addr,
    output logic [ELEN-1:0]  mem_wdata,
    input  logic [ELEN-1:0]  mem_rdata
);
    localparam int IDX_W = (VLMAX > 1) ? $clog2(VLMAX) : 1;

    seq_state_e                 state_q;
    logic [CNT_W-1:0]           i_q;
    logic [CNT_W-1:0]           vl_q;
    logic [CNT_W-1:0]           i_inc;
    amo_op_e                    op_q;
    logic                       mem64_q;
    logic                       elem64_q;
    logic                       vm_q;
    logic                       wd_q;
    logic                       ok_q;
    logic                       illegal_q;
    logic                       fault_q;
    logic [VLMAX-1:0]           mask_q;
    logic [XLEN-1:0]            base_q;
    logic [VW-1:0]              idx_q;
    logic [VW-1:0]              data_q;
    logic [ELEN-1:0]            old_q;
    logic [ELEN-1:0]            st_q;

    logic                       dec_legal;
    amo_op_e                    dec_op;
    logic                       dec_mem64;
    logic                       dec_elem64;
    logic [VLMAX-1:0][XLEN-1:0] elem_addr;
    logic [IDX_W-1:0]           slot;
    logic                       active;
    logic                       last;
    logic [ELEN-1:0]            cur_elem;
    logic [ELEN-1:0]            st_d;
    logic [ELEN-1:0]            wb_val;

    vamo_decode #(.XLEN(XLEN), .VLMAX(VLMAX)) dec_i (
        .funct5 (funct5),
        .width  (width),
        .sew    (sew),
        .vl     (vl),
        .legal  (dec_legal),
        .op     (dec_op),
        .mem64  (dec_mem64),
        .elem64 (dec_elem64)
    );

    vamo_addr_gen #(.XLEN(XLEN), .VLMAX(VLMAX)) agen_i (
        .base      (base_q),
        .index_vec (idx_q),
        .elem64    (elem64_q),
        .elem_addr (elem_addr)
    );

    vamo_alu alu_i (
        .op        (op_q),
        .mem64     (mem64_q),
        .mem_val   (mem_rdata),
        .vec_val   (cur_elem),
        .store_val (st_d)
    );

    // Current element selection, activity and end-of-pass detection.
    always_comb begin
        slot     = i_q[IDX_W-1:0];
        active   = vm_q | mask_q[slot];
        i_inc    = i_q + CNT_W'(1);
        last     = (i_inc == vl_q);
        cur_elem = data_q[slot*ELEN +: ELEN];
    end

    // Writeback value: sign-extend a 32-bit load into 64-bit elements.
    always_comb begin
        if (elem64_q)
            wb_val = mem64_q ? old_q : {{32{old_q[31]}}, old_q[31:0]};
        else
            wb_val = {32'b0, old_q[31:0]};
    end

    // Main sequencer: latch, permission pass, RMW pass, tail clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            i_q       <= '0;
            vl_q      <= '0;
            op_q      <= OP_SWAP;
            mem64_q   <= 1'b0;
            elem64_q  <= 1'b0;
            vm_q      <= 1'b1;
            wd_q      <= 1'b0;
            ok_q      <= 1'b0;
            illegal_q <= 1'b0;
            fault_q   <= 1'b0;
            mask_q    <= '0;
            base_q    <= '0;
            idx_q     <= '0;
            data_q    <= '0;
            old_q     <= '0;
            st_q      <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        op_q      <= dec_op;
                        mem64_q   <= dec_mem64;
                        elem64_q  <= dec_elem64;
                        vm_q      <= vm;
                        wd_q      <= wd;
                        vl_q      <= vl;
                        mask_q    <= mask;
                        base_q    <= base;
                        idx_q     <= index_vec;
                        data_q    <= data_vec;
                        i_q       <= '0;
                        ok_q      <= 1'b0;
                        fault_q   <= 1'b0;
                        illegal_q <= !dec_legal;
                        state_q   <= (!dec_legal || vl == '0) ? ST_FIN : ST_CHK;
                    end
                end
                ST_CHK: begin
                    if (active && !(chk_ld_ok && chk_st_ok)) begin
                        fault_q <= 1'b1;
                        state_q <= ST_FIN;
                    end else if (last) begin
                        i_q     <= '0;
                        state_q <= ST_RD;
                    end else begin
                        i_q <= i_inc;
                    end
                end
                ST_RD: begin
                    if (active) begin
                        state_q <= ST_LD;
                    end else if (last) begin
                        ok_q    <= 1'b1;
                        state_q <= ST_FIN;
                        for (int k = 0; k < VLMAX; k++)
                            if (k >= int'(vl_q)) data_q[k*ELEN +: ELEN] <= '0;
                    end else begin
                        i_q <= i_inc;
                    end
                end
                ST_LD: begin
                    old_q   <= mem_rdata;
                    st_q    <= st_d;
                    state_q <= ST_WR;
                end
                ST_WR: begin
                    if (wd_q) data_q[slot*ELEN +: ELEN] <= wb_val;
                    if (last) begin
                        ok_q    <= 1'b1;
                        state_q <= ST_FIN;
                        for (int k = 0; k < VLMAX; k++)
                            if (k >= int'(vl_q)) data_q[k*ELEN +: ELEN] <= '0;
                    end else begin
                        i_q     <= i_inc;
                        state_q <= ST_RD;
                    end
                end
                ST_FIN: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Port drive from the sequencer state.
    always_comb begin
        busy       = (state_q != ST_IDLE);
        done       = (state_q == ST_FIN);
        illegal    = illegal_q;
        fault      = fault_q;
        dst_valid  = done && ok_q;
        dst_vec    = data_q;
        chk_req    = (state_q == ST_CHK) && active;
        chk_addr   = elem_addr[slot];
        mem_req    = ((state_q == ST_RD) && active) || (state_q == ST_WR);
        mem_we     = (state_q == ST_WR);
        mem_size64 = mem64_q;
        mem_addr   = elem_addr[slot];
        mem_wdata  = st_q;
    end
endmodule

// File: rtl/vamo_seq_chk.sv
// Protocol checker for the sequencer, bound into every instance.
// Assumes the port timing stated in the sequencer header.
module vamo_seq_chk #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            busy,
    input logic            done,
    input logic            illegal,
    input logic            fault,
    input logic            dst_valid,
    input logic            chk_req,
    input logic            mem_req,
    input logic            mem_we,
    input logic [XLEN-1:0] mem_addr
);
    logic seen_q;

    // Track whether any memory request occurred since the last accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n)                seen_q <= 1'b0;
        else if (start && !busy)   seen_q <= 1'b0;
        else if (mem_req)          seen_q <= 1'b1;
    end

    assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_start_busy_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_rmw_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> ($past(mem_req && !mem_we, 2) && mem_addr == $past(mem_addr, 2)));

    assert_no_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !dst_valid) |-> !seen_q);

    assert_pass_split_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !chk_req);

    assert_status_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dst_valid |-> (!illegal && !fault));
endmodule

bind vamo_seq vamo_seq_chk #(.XLEN(XLEN)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .illegal   (illegal),
    .fault     (fault),
    .dst_valid (dst_valid),
    .chk_req   (chk_req),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr)
);

// File: tb/vamo_seq_tb.sv
// Self-checking bench: seeded random runs plus directed corner cases.
module vamo_seq_tb_top;
    localparam int VL = 8;
    localparam int NW = 32;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [4:0]      funct5 = '0;
    logic [2:0]      width = 3'b110;
    logic [1:0]      sew = 2'd2;
    logic            vm = 1'b1;
    logic            wd = 1'b0;
    logic [3:0]      vl = '0;
    logic [63:0]     base = '0;
    logic [VL*64-1:0] index_vec;
    logic [VL*64-1:0] data_vec;
    logic [VL-1:0]   mask = '0;
    logic            busy, done, illegal, fault, dst_valid;
    logic [VL*64-1:0] dst_vec;
    logic            chk_req, chk_ld_ok, chk_st_ok;
    logic [63:0]     chk_addr;
    logic            mem_req, mem_we, mem_size64;
    logic [63:0]     mem_addr, mem_wdata;
    logic [63:0]     mem_rdata = '0;

    logic [63:0] idx_a [VL];
    logic [63:0] src_a [VL];
    logic [63:0] seed_arr [NW];
    logic [63:0] mem_arr [NW];
    logic [63:0] exp_mem [NW];
    logic [63:0] exp_dst [VL];
    logic [63:0] bad_ld = '1;
    logic [63:0] bad_st = '1;
    logic        seed_en = 1'b0;
    int          acc_cnt = 0;
    int          n_run = 0;
    int          n_fail = 0;
    int          cyc = 0;
    logic        hung = 1'b0;
    logic        poke = 1'b0;

    always #2 clk = ~clk;

    for (genvar g = 0; g < VL; g++) begin : g_pack
        assign index_vec[g*64 +: 64] = idx_a[g];
        assign data_vec[g*64 +: 64]  = src_a[g];
    end

    assign chk_ld_ok = (chk_addr != bad_ld);
    assign chk_st_ok = (chk_addr != bad_st);

    vamo_seq #(.XLEN(64), .VLMAX(VL)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .funct5(funct5), .width(width),
        .sew(sew), .vm(vm), .wd(wd), .vl(vl), .base(base), .index_vec(index_vec),
        .data_vec(data_vec), .mask(mask), .busy(busy), .done(done),
        .illegal(illegal), .fault(fault), .dst_valid(dst_valid), .dst_vec(dst_vec),
        .chk_req(chk_req), .chk_addr(chk_addr), .chk_ld_ok(chk_ld_ok),
        .chk_st_ok(chk_st_ok), .mem_req(mem_req), .mem_we(mem_we),
        .mem_size64(mem_size64), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    // Memory model: registered read, 32-bit writes touch the low half only.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (seed_en) begin
            for (int k = 0; k < NW; k++) mem_arr[k] <= seed_arr[k];
            acc_cnt <= 0;
        end else if (mem_req) begin
            acc_cnt <= acc_cnt + 1;
            if (mem_we) begin
                if (mem_size64) mem_arr[mem_addr[7:3]] <= mem_wdata;
                else mem_arr[mem_addr[7:3]][31:0] <= mem_wdata[31:0];
            end else begin
                mem_rdata <= mem_arr[mem_addr[7:3]];
            end
        end
    end

    task automatic check(input logic ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_amo(input logic [4:0] f5, input logic m64,
                                            input logic [63:0] mv, input logic [63:0] vv);
        logic [63:0] a, b, r;
        logic sg, lt;
        sg = (f5 == 5'b10000) || (f5 == 5'b10100);
        if (m64) begin a = mv; b = vv; end
        else begin
            a = sg ? {{32{mv[31]}}, mv[31:0]} : {32'h0, mv[31:0]};
            b = sg ? {{32{vv[31]}}, vv[31:0]} : {32'h0, vv[31:0]};
        end
        lt = sg ? ($signed(a) < $signed(b)) : (a < b);
        case (f5)
            5'b00001: r = vv;
            5'b00000: r = a + b;
            5'b00100: r = a ^ b;
            5'b01100: r = a & b;
            5'b01000: r = a | b;
            5'b10000, 5'b11000: r = lt ? a : b;
            default: r = lt ? b : a;
        endcase
        return r;
    endfunction

    function automatic logic known_op(input logic [4:0] f5);
        return f5 inside {5'b00001, 5'b00000, 5'b00100, 5'b01100, 5'b01000,
                          5'b10000, 5'b10100, 5'b11000, 5'b11100};
    endfunction

    // One instruction: reference model, drive, wait for done, compare.
    task automatic run_case(input logic [4:0] f5, input logic [2:0] wid, input logic [1:0] sw,
                            input logic v_m, input logic w_d, input logic [3:0] n,
                            input logic [7:0] msk, input logic [63:0] bs, input string tag);
        logic legal, e_fault, m64, e64, act;
        logic [63:0] ad, ix, r, old;
        int exp_acc, waited;
        for (int k = 0; k < NW; k++) seed_arr[k] = {$urandom, $urandom};
        if (tag == "R10") for (int k = 0; k < NW; k++) seed_arr[k] = src_a[k % VL];
        for (int k = 0; k < NW; k++) exp_mem[k] = seed_arr[k];
        for (int k = 0; k < VL; k++) exp_dst[k] = src_a[k];
        m64 = (wid == 3'b111);
        e64 = (sw == 2'd3);
        legal = known_op(f5) && sw >= 2'd2 && (wid == 3'b110 || (m64 && e64)) && n <= 4'd8;
        e_fault = 1'b0;
        exp_acc = 0;
        if (legal) begin
            for (int k = 0; k < int'(n); k++) begin
                ix = e64 ? idx_a[k] : {32'h0, idx_a[k][31:0]};
                ad = bs + ix;
                act = v_m || msk[k];
                if (act && (ad == bad_ld || ad == bad_st)) e_fault = 1'b1;
            end
            if (!e_fault && n != 0) begin
                for (int k = 0; k < int'(n); k++) begin
                    if (!(v_m || msk[k])) continue;
                    ix = e64 ? idx_a[k] : {32'h0, idx_a[k][31:0]};
                    ad = bs + ix;
                    old = exp_mem[ad[7:3]];
                    r = ref_amo(f5, m64, old, src_a[k]);
                    if (m64) exp_mem[ad[7:3]] = r;
                    else exp_mem[ad[7:3]] = {old[63:32], r[31:0]};
                    if (w_d) exp_dst[k] = e64 ? (m64 ? old : {{32{old[31]}}, old[31:0]})
                                              : {32'h0, old[31:0]};
                    exp_acc += 2;
                end
                for (int k = int'(n); k < VL; k++) exp_dst[k] = '0;
            end
        end
        @(negedge clk);
        seed_en = 1'b1;
        @(negedge clk);
        seed_en = 1'b0;
        funct5 = f5; width = wid; sew = sw; vm = v_m; wd = w_d; vl = n; mask = msk; base = bs;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        waited = 1;
        if (poke && !done) begin
            start = 1'b1; funct5 = 5'b00010; vl = 4'd0;
        end
        while (!done && waited < 200) begin
            @(negedge clk);
            start = 1'b0;
            waited++;
        end
        start = 1'b0;
        if (!done) begin hung = 1'b1; check(1'b0, "R13 watchdog", 64'(waited), 64'd0); end
        check(illegal == !legal, "R2", 64'(illegal), 64'(!legal));
        check(fault == e_fault, "R5", 64'(fault), 64'(e_fault));
        check(dst_valid == (legal && !e_fault && n != 0), "R8", 64'(dst_valid),
              64'(legal && !e_fault && n != 0));
        if (!legal || n == 0) check(waited == 1, "R8 latency", 64'(waited), 64'd1);
        if (legal && !e_fault && n != 0)
            for (int k = 0; k < VL; k++)
                if (dst_vec[k*64 +: 64] !== exp_dst[k]) begin
                    check(1'b0, {tag, " dst"}, dst_vec[k*64 +: 64], exp_dst[k]);
                    break;
                end
        @(negedge clk);
        check(!done, "R13 pulse", 64'(done), 64'd0);
        check(acc_cnt == exp_acc, "R4", 64'(acc_cnt), 64'(exp_acc));
        begin
            logic mm;
            mm = 1'b0;
            for (int k = 0; k < NW; k++)
                if (!mm && mem_arr[k] !== exp_mem[k]) begin
                    mm = 1'b1;
                    check(1'b0, {tag, " mem"}, mem_arr[k], exp_mem[k]);
                end
            if (!mm) check(1'b1, tag, 64'd0, 64'd0);
        end
    endtask

    task automatic fill_vec(input logic e64);
        for (int k = 0; k < VL; k++) begin
            idx_a[k] = 64'(8 * ($urandom % 24));
            if (!e64) idx_a[k][63:32] = $urandom;
            src_a[k] = {$urandom, $urandom};
        end
    endtask

    localparam logic [4:0] OPS [9] = '{5'b00001, 5'b00000, 5'b00100, 5'b01100, 5'b01000,
                                       5'b10000, 5'b10100, 5'b11000, 5'b11100};

    initial begin
        void'($urandom(32'd1234));
        for (int k = 0; k < VL; k++) begin idx_a[k] = '0; src_a[k] = '0; end
        repeat (4) @(negedge clk);
        check(!busy && !done && !mem_req && !chk_req, "R13 reset", 64'(busy), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed: zero length, illegal settings.
        fill_vec(1'b1);
        run_case(5'b00000, 3'b111, 2'd3, 1'b1, 1'b1, 4'd0, 8'hFF, 64'd8, "R8");
        run_case(5'b00010, 3'b110, 2'd2, 1'b1, 1'b1, 4'd4, 8'hFF, 64'd8, "R2");
        run_case(5'b00000, 3'b101, 2'd2, 1'b1, 1'b1, 4'd4, 8'hFF, 64'd8, "R2");
        run_case(5'b00000, 3'b110, 2'd1, 1'b1, 1'b1, 4'd4, 8'hFF, 64'd8, "R2");
        run_case(5'b00000, 3'b111, 2'd2, 1'b1, 1'b1, 4'd4, 8'hFF, 64'd8, "R2");
        run_case(5'b00000, 3'b111, 2'd3, 1'b1, 1'b1, 4'd9, 8'hFF, 64'd8, "R2");

        // Permission faults on load side and store side.
        fill_vec(1'b1);
        bad_ld = 64'd16 + idx_a[3];
        run_case(5'b00000, 3'b111, 2'd3, 1'b1, 1'b0, 4'd6, 8'hFF, 64'd16, "R5");
        bad_ld = '1; bad_st = 64'd16 + idx_a[5];
        run_case(5'b01000, 3'b111, 2'd3, 1'b1, 1'b1, 4'd6, 8'hFF, 64'd16, "R5");
        bad_st = '1;

        // All masked off: no access, body kept, tail zeroed.
        fill_vec(1'b1);
        run_case(5'b00000, 3'b111, 2'd3, 1'b0, 1'b1, 4'd5, 8'h00, 64'd0, "R9");

        // Repeated address: later element sees the earlier update.
        fill_vec(1'b1);
        for (int k = 0; k < VL; k++) idx_a[k] = 64'd40;
        run_case(5'b00000, 3'b111, 2'd3, 1'b1, 1'b1, 4'd8, 8'hFF, 64'd8, "R6");

        // Index zero-extension with junk in the high half.
        fill_vec(1'b0);
        run_case(5'b00100, 3'b110, 2'd2, 1'b1, 1'b1, 4'd7, 8'hFF, 64'd24, "R3");

        // Add wrap at both widths, swap.
        fill_vec(1'b1);
        for (int k = 0; k < VL; k++) src_a[k] = 64'hFFFF_FFFF_FFFF_FFFF;
        run_case(5'b00000, 3'b111, 2'd3, 1'b1, 1'b1, 4'd8, 8'hFF, 64'd0, "R12");
        run_case(5'b00000, 3'b110, 2'd3, 1'b1, 1'b1, 4'd8, 8'hFF, 64'd0, "R12");
        run_case(5'b00001, 3'b111, 2'd3, 1'b1, 1'b1, 4'd8, 8'hFF, 64'd0, "R12");

        // 32-bit memory with 64-bit elements: truncation and sign extension.
        fill_vec(1'b1);
        for (int k = 0; k < VL; k++) src_a[k] = {$urandom, 1'b1, 31'($urandom)};
        run_case(5'b10100, 3'b110, 2'd3, 1'b1, 1'b1, 4'd8, 8'hFF, 64'd0, "R11");

        // Min/max with equal operands (memory seeded from element values).
        for (int m = 5; m < 9; m++) begin
            fill_vec(1'b1);
            for (int k = 0; k < VL; k++) idx_a[k] = 64'(8 * k);
            run_case(OPS[m], 3'b111, 2'd3, 1'b1, 1'b1, 4'd8, 8'hFF, 64'd0, "R10");
            run_case(OPS[m], 3'b110, 2'd2, 1'b1, 1'b1, 4'd8, 8'hFF, 64'd0, "R10");
        end

        // Start pulse while busy is ignored.
        fill_vec(1'b1);
        poke = 1'b1;
        run_case(5'b01100, 3'b111, 2'd3, 1'b1, 1'b1, 4'd6, 8'hFF, 64'd8, "R13");
        poke = 1'b0;

        // Seeded random mix.
        for (int t = 0; t < 80 && !hung; t++) begin
            logic [1:0] s;
            logic [2:0] w;
            s = ($urandom % 2) ? 2'd3 : 2'd2;
            w = (s == 2'd3 && ($urandom % 2)) ? 3'b111 : 3'b110;
            fill_vec(s == 2'd3);
            run_case(OPS[$urandom % 9], w, s, 1'($urandom), 1'($urandom),
                     4'(1 + $urandom % 8), 8'($urandom), 64'(8 * ($urandom % 8)),
                     (t % 2) ? "R1" : "R7");
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Global watchdog.
    initial begin
        #400000;
        n_run++;
        n_fail++;
        $display("FAIL R13 watchdog actual=%0d expected=done", cyc);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule